// File: doc/BRIEF.md
# Watchdog Reset Gating and Status

This block sits between a watchdog timer and the system reset generator. The watchdog raises a reset request. The block decides whether that request may reach the reset generator, using a mask bit and an auto-disable bit held in small registers. When a request is let through, the block drives the reset output for exactly one clock and records in a sticky status flag that the watchdog caused the reset. The block also holds the bit that lets the watchdog counter run, and drives it out to the watchdog's enable input.

Build parameters set the mask polarity and the bit positions of the fields. When `MASK_INV` is 0, a set mask bit blocks forwarding. When it is 1, a set mask bit allows forwarding. The control registers return to their power-on values on the warm (system) reset. The status flag is cleared only by power-on reset or by software writing 1 to it, so it survives the reset that it records.

A three-state machine handles each request:
- `ST_IDLE` waits for a request.
- `ST_FIRE` is the single pulse cycle.
- `ST_DRAIN` waits for the request to fall.

The transitions are:
- idle to fire when a request arrives and the gate is open.
- idle to drain when a request arrives and the gate is blocked; the request is discarded.
- fire to drain when the request is still high.
- fire to idle when the request is already low.
- drain to idle once the request falls.

Top module: `wdt_rst_gate`

## Requirements
- R1: After power-on reset, all of the following hold: the mask field is at the blocking value (bit `CTL_BIT` of register 0 reads `!MASK_INV`, which is 1 by default), the auto-disable field and the counter-enable field read 0, the status field reads 0, and `wdt_rst_out` is 0.
- R2: The register map is: address 0 holds the mask field, address 1 the auto-disable field, and address 2 the counter-enable field, each at bit `CTL_BIT` (default 0). Address 3 holds the status field at bit `STAT_BIT` (default 1). A read returns the field at its position and 0 in every other bit. Writes to other bit positions have no effect.
- R3: With `MASK_INV`=0, a request is forwarded only when the mask field is 0; a mask field of 1 blocks it.
- R4: While the auto-disable field is 1 and `cpu_in_rst` is 1, a request is not forwarded. When either of them is 0, the auto-disable path does not block.
- R5: A forwarded request drives `wdt_rst_out` high for exactly one clock. The pulse starts in the cycle after the first clock edge that samples the request, and a request held high produces only one pulse.
- R6: A request that arrives while forwarding is blocked is discarded. Lifting the block while that request is still high produces no pulse; the request must fall first.
- R7: `rst_by_wdt` goes to 1 in the same cycle as the forwarded pulse and stays 1.
- R8: While `warm_rst_n` is low at a clock edge, the mask, auto-disable and counter-enable fields return to their power-on values, and the status field keeps its value.
- R9: Writing 1 to bit `STAT_BIT` of address 3 clears the status. Writing 0 there, or writing to any other address, leaves it unchanged.
- R10: `wdt_cnt_en` equals the counter-enable field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst_n | input | 1 | System reset, synchronous, active low; status is kept |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| wdt_req | input | 1 | Reset request from the watchdog (level) |
| cpu_in_rst | input | 1 | The associated processor is held in reset |
| wdt_rst_out | output | 1 | One-cycle reset request to the reset generator |
| wdt_cnt_en | output | 1 | Enable for the watchdog counter |
| rst_by_wdt | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
The hardest case to reach is a request that was discarded while blocked and is still held high when the block is lifted. In that case the machine must stay in the drain state and produce no pulse. A directed sequence reaches it by raising the request while the processor is in reset with auto-disable set, then releasing `cpu_in_rst` without dropping the request. Random rounds then mix mask and auto-disable writes, processor-reset levels, warm resets and status clears. Each round's pulse count and status are compared with values that bench functions compute from the requirements.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
    localparam int AW = 2;
    localparam logic [AW-1:0] A_MASK = 2'd0;
    localparam logic [AW-1:0] A_AUTO = 2'd1;
    localparam logic [AW-1:0] A_CNT  = 2'd2;
    localparam logic [AW-1:0] A_STAT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRE  = 2'd1,
        ST_DRAIN = 2'd2
    } gate_st_e;
endpackage

// File: rtl/wrg_regs.sv
module wrg_regs
    import wrg_pkg::*;
#(
    parameter int DW       = 32,
    parameter int CTL_BIT  = 0,
    parameter int STAT_BIT = 1,
    parameter bit MASK_INV = 1'b0
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          warm_rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          set_stat,
    output logic [DW-1:0] rdata,
    output logic          mask_q,
    output logic          auto_q,
    output logic          cnt_q,
    output logic          stat_q
);
    localparam logic MASK_POR = ~MASK_INV;

    logic clr_stat;
    assign clr_stat = wr_en && (addr == A_STAT) && wdata[STAT_BIT];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mask_q <= MASK_POR;
            auto_q <= 1'b0;
            cnt_q  <= 1'b0;
        end else if (!warm_rst_n) begin
            mask_q <= MASK_POR;
            auto_q <= 1'b0;
            cnt_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_MASK:  mask_q <= wdata[CTL_BIT];
                A_AUTO:  auto_q <= wdata[CTL_BIT];
                A_CNT:   cnt_q  <= wdata[CTL_BIT];
                default: ;
            endcase
        end
    end

    // status: only power-on clears it in hardware; set wins over a same-cycle clear
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        stat_q <= 1'b0;
        else if (set_stat) stat_q <= 1'b1;
        else if (clr_stat) stat_q <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MASK: rdata[CTL_BIT]  = mask_q;
            A_AUTO: rdata[CTL_BIT]  = auto_q;
            A_CNT:  rdata[CTL_BIT]  = cnt_q;
            A_STAT: rdata[STAT_BIT] = stat_q;
            default: ;
        endcase
    end

    // R8
    warm_defaults_chk: assert property (@(posedge clk) disable iff (!por_n)
        !warm_rst_n |=> (mask_q == MASK_POR) && !auto_q && !cnt_q);
    // R9
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        stat_q && !(wr_en && addr == A_STAT && wdata[STAT_BIT]) |=> stat_q);
    // R7
    stat_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        set_stat |=> stat_q);
endmodule

// File: rtl/wrg_fsm.sv
module wrg_fsm
    import wrg_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic req,
    input  logic blocked,
    output logic fire_next,
    output logic pulse
);
    gate_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req) st_d = blocked ? ST_DRAIN : ST_FIRE;
            ST_FIRE:  st_d = req ? ST_DRAIN : ST_IDLE;
            ST_DRAIN: if (!req) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        fire_next = (st_d == ST_FIRE);
        pulse     = (st_q == ST_FIRE);
    end

    // R5
    one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        pulse |=> !pulse);
    // R5
    pulse_needs_req_chk: assert property (@(posedge clk) disable iff (!por_n)
        pulse |-> $past(req));
    // R3
    blocked_no_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        blocked |=> !pulse);
endmodule

// File: rtl/wdt_rst_gate.sv
module wdt_rst_gate
    import wrg_pkg::*;
#(
    parameter int DW       = 32,
    parameter int CTL_BIT  = 0,
    parameter int STAT_BIT = 1,
    parameter bit MASK_INV = 1'b0
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          warm_rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          wdt_req,
    input  logic          cpu_in_rst,
    output logic          wdt_rst_out,
    output logic          wdt_cnt_en,
    output logic          rst_by_wdt
);
    logic mask_q, auto_q, cnt_q, stat_q, fire_next, blocked;

    assign blocked = (mask_q ^ MASK_INV) | (auto_q & cpu_in_rst);

    wrg_regs #(.DW(DW), .CTL_BIT(CTL_BIT), .STAT_BIT(STAT_BIT), .MASK_INV(MASK_INV)) u_regs (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .set_stat(fire_next), .rdata(reg_rdata),
        .mask_q(mask_q), .auto_q(auto_q), .cnt_q(cnt_q), .stat_q(stat_q)
    );

    wrg_fsm u_fsm (
        .clk(clk), .por_n(por_n), .req(wdt_req), .blocked(blocked),
        .fire_next(fire_next), .pulse(wdt_rst_out)
    );

    assign wdt_cnt_en = cnt_q;
    assign rst_by_wdt = stat_q;

    // R7
    pulse_sets_status_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_out |-> rst_by_wdt);
    // R4
    auto_block_chk: assert property (@(posedge clk) disable iff (!por_n)
        (auto_q && cpu_in_rst) |=> !wdt_rst_out);
endmodule

// File: tb/wdt_rst_gate_bench.sv
module wdt_rst_gate_bench;
    localparam int DW = 32;
    localparam int CB = 0;
    localparam int SB = 1;

    logic clk = 0, por_n = 0, warm_rst_n = 1, reg_wr = 0, wdt_req = 0, cpu_in_rst = 0;
    logic [1:0] reg_addr = 0;
    logic [DW-1:0] reg_wdata = 0, reg_rdata;
    logic wdt_rst_out, wdt_cnt_en, rst_by_wdt;
    int total = 0, bad = 0;
    bit m_mask, m_auto, m_cnt, m_stat;

    always #10 clk = ~clk;

    wdt_rst_gate u_wdt_rst_gate (.*);

    function automatic bit open_gate(bit mk, bit au, bit cpu);
        return !mk && !(au && cpu);
    endfunction

    task automatic chk(string rq, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_chk(string rq, logic [1:0] a, logic [DW-1:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(rq, reg_rdata, exp);
    endtask

    task automatic warm;
        @(negedge clk); warm_rst_n = 0;
        @(negedge clk); warm_rst_n = 1;
        m_mask = 1; m_auto = 0; m_cnt = 0;
    endtask

    // request high for 3 sampling edges, then low; count pulses and check timing
    task automatic req_round(string rq, bit exp_fire);
        int cnt = 0; bit first = 0;
        @(negedge clk); wdt_req = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (wdt_rst_out) begin cnt++; if (i == 0) first = 1; end
            if (i == 2) wdt_req = 0;
        end
        chk({rq, " pulse count"}, cnt, exp_fire ? 1 : 0);
        if (exp_fire) begin
            chk("R5 pulse in first cycle", first, 1);
            m_stat = 1;
        end
        chk("R7 status", rst_by_wdt, m_stat);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        por_n = 1;
        m_mask = 1; m_auto = 0; m_cnt = 0; m_stat = 0;
        // R1
        rd_chk("R1 mask", 0, 32'h1);
        rd_chk("R1 auto", 1, 0);
        rd_chk("R1 cnt", 2, 0);
        rd_chk("R1 status", 3, 0);
        chk("R1 rst_out", wdt_rst_out, 0);
        // R3 blocked at power-on
        req_round("R3 masked", 0);
        // R2 other bits ignored
        wr(1, 32'hFFFF_FFFE);
        rd_chk("R2 ignore other bits", 1, 0);
        wr(2, 32'hFFFF_FFFF); m_cnt = 1;
        rd_chk("R2 cnt readback", 2, 32'h1);
        chk("R10 cnt_en", wdt_cnt_en, 1);
        // R3 open, R5, R7
        wr(0, 0); m_mask = 0;
        req_round("R3 open", 1);
        rd_chk("R2 status position", 3, 32'h2);
        // R9 write 0 keeps, write 1 clears
        wr(3, 32'hFFFF_FFFD);
        rd_chk("R9 write0 keeps", 3, 32'h2);
        wr(0, 0);
        chk("R9 other addr keeps", rst_by_wdt, 1);
        // R8 warm reset keeps status
        warm;
        chk("R8 status kept", rst_by_wdt, 1);
        rd_chk("R8 mask default", 0, 32'h1);
        chk("R8 cnt default", wdt_cnt_en, 0);
        wr(3, 32'h2); m_stat = 0;
        chk("R9 clear", rst_by_wdt, 0);
        // R6 discarded request while blocked, then block lifted with request still high
        wr(0, 0); m_mask = 0;
        wr(1, 1); m_auto = 1;
        @(negedge clk); cpu_in_rst = 1; wdt_req = 1;
        repeat (2) @(negedge clk);
        cpu_in_rst = 0;
        begin
            int c = 0;
            for (int i = 0; i < 4; i++) begin @(negedge clk); if (wdt_rst_out) c++; end
            chk("R6 no pulse after lift", c, 0);
        end
        wdt_req = 0;
        repeat (2) @(negedge clk);
        chk("R4 status stays clear", rst_by_wdt, 0);
        req_round("R4 auto but cpu running", 1);
        // random rounds
        for (int n = 0; n < 60; n++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) warm;
            else if (op == 1) begin wr(3, 32'h2); m_stat = 0; end
            else begin
                bit mk = $urandom_range(0, 3) == 0;
                bit au = $urandom_range(0, 1);
                bit cn = $urandom_range(0, 1);
                wr(0, {$urandom} & ~32'h1 | mk); m_mask = mk;
                wr(1, {$urandom} & ~32'h1 | au); m_auto = au;
                wr(2, {$urandom} & ~32'h1 | cn); m_cnt = cn;
                @(negedge clk); cpu_in_rst = $urandom_range(0, 1);
                chk("R10 cnt_en", wdt_cnt_en, m_cnt);
                req_round(mk ? "R3 rand" : "R4 rand", open_gate(m_mask, m_auto, cpu_in_rst));
            end
            rd_chk("R2 rand mask read", 0, {31'b0, m_mask});
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule